// File: doc/BRIEF.md
# Save Monitor Data Request Generator

This block creates a one-cycle pulse that tells downstream crates to save their monitoring data. A crate controller drives two request lines. The first line arms a save. The save then fires on the first later trigger accept that arrives inside the accept period with its status-collection qualifier bit set. The second line forces a save at once, with no trigger involved. Only crate 0 drives these lines. The same inputs from the other crate positions are spare and have no effect.

All asynchronous inputs pass through a two-flop synchronizer before any logic uses them. Three indicator outputs drive front-panel lamps. One shows the save pulse stretched to a fixed time that is long enough to see (10 ms by default, computed from a clock-frequency parameter). The other two show the synchronized levels of the two request lines.

Top module: `save_mon_gen`

## Requirements
- R1: If an arm request was registered earlier, a one-cycle accept with the period input high and qualifier bit 7 high raises `save_o` for exactly one clock. That clock is the third rising edge after the edge that first samples the accept.
- R2: A rising edge on force request line 0 raises `save_o` for exactly one clock, three edges after it is sampled. A force line held high gives only one pulse.
- R3: An accept gives no save while the period input is low or qualifier bit 7 is low. Qualifier bits 0 to 6 have no effect.
- R4: The arm flag clears when it issues a save, so a second qualified accept with no new arm request gives no save.
- R5: A qualified accept with no pending arm gives no save.
- R6: `save_led_o` goes high one clock after `save_o`. It stays high for (CLK_HZ/1000)*STRETCH_MS clocks. Every new save restarts that time.
- R7: `arm_led_o` and `force_led_o` follow request lines 0 two clocks after the input changes.
- R8: Request bits 1 and above (the spare crates) are ignored. They do not arm, do not force and do not light the indicators.
- R9: While `rst` is high, all outputs are low and no arm is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_req_i | input | N_CRATES | Arm-on-next-qualified-accept request, one bit per crate (bit 0 used) |
| force_req_i | input | N_CRATES | Immediate save request, one bit per crate (bit 0 used) |
| trig_accept_i | input | 1 | Trigger accept strobe |
| trig_period_i | input | 1 | Accept period, qualifies the strobe |
| trig_qual_i | input | QUAL_W | Accept qualifier field; bit STAT_BIT requests status collection |
| save_o | output | 1 | One-cycle save monitor data pulse |
| save_led_o | output | 1 | Stretched copy of the save pulse |
| arm_led_o | output | 1 | Synchronized arm request level |
| force_led_o | output | 1 | Synchronized force request level |

## Verification
Every input reaches the logic after two synchronizer flops. Because of this, an indicator changes two clocks after its input, and a save pulse appears on the third clock after a force edge or after the accept strobe. The stretched lamp turns on one clock later, and it turns off STRETCH cycles after the save that last loaded it. The bench drives inputs on falling edges and counts falling edges from the drive point to the exact clock where each result is due. At that clock it checks the level, and on the next clock it checks that the pulse has ended. Negative cases use a save counter sampled on falling edges. The bench compares that counter across a quiet window that is longer than any latency.

// File: rtl/save_mon_pkg.sv
package save_mon_pkg;

    // Synchronized request / trigger bundle
    typedef struct packed {
        logic arm;
        logic frc;
        logic acc;
        logic per;
        logic stat;
    } sm_req_t;

    // Origin of an issued save
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_ARM  = 2'b01,
        SRC_FRC  = 2'b10,
        SRC_BOTH = 2'b11
    } save_src_e;

    // Number of clocks the lamp stays lit
    function automatic int stretch_len(input int clk_hz, input int ms);
        int n;
        n = (clk_hz / 1000) * ms;
        return (n < 1) ? 1 : n;
    endfunction

    // Counter width able to hold n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q_o = stage[STAGES-1];
endmodule

// File: rtl/sm_save_ctrl.sv
module sm_save_ctrl
    import save_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sm_req_t req_i,
    output logic    save_o,
    output logic    arm_pend_o,
    output logic    frc_edge_o
);
    logic      arm_prev, frc_prev, arm_pend, save_q;
    logic      arm_rise, frc_edge, acc_hit, arm_fire;
    save_src_e src;

    assign arm_rise = req_i.arm & ~arm_prev;
    assign frc_edge = req_i.frc & ~frc_prev;
    assign acc_hit  = req_i.acc & req_i.per & req_i.stat;
    assign arm_fire = arm_pend & acc_hit;
    assign src      = save_src_e'({frc_edge, arm_fire});

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_prev <= 1'b0;
            frc_prev <= 1'b0;
            arm_pend <= 1'b0;
            save_q   <= 1'b0;
        end else begin
            arm_prev <= req_i.arm;
            frc_prev <= req_i.frc;
            // a fresh arm request wins over clearing by the current fire
            arm_pend <= (arm_pend & ~arm_fire) | arm_rise;
            save_q   <= (src != SRC_NONE);
        end
    end

    assign save_o     = save_q;
    assign arm_pend_o = arm_pend;
    assign frc_edge_o = frc_edge;
endmodule

// File: rtl/sm_stretch.sv
module sm_stretch #(
    parameter int LEN = 10,
    parameter int W   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic led_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (trig_i)      cnt <= W'(LEN);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign led_o = (cnt != '0);
endmodule

// File: rtl/save_mon_gen.sv
module save_mon_gen
    import save_mon_pkg::*;
#(
    parameter int CLK_HZ     = 53_000_000,
    parameter int STRETCH_MS = 10,
    parameter int N_CRATES   = 4,
    parameter int QUAL_W     = 8,
    parameter int STAT_BIT   = 7,
    parameter int SYNC_STG   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CRATES-1:0] arm_req_i,
    input  logic [N_CRATES-1:0] force_req_i,
    input  logic                trig_accept_i,
    input  logic                trig_period_i,
    input  logic [QUAL_W-1:0]   trig_qual_i,
    output logic                save_o,
    output logic                save_led_o,
    output logic                arm_led_o,
    output logic                force_led_o
);
    localparam int STRETCH = stretch_len(CLK_HZ, STRETCH_MS);
    localparam int CNT_W   = cnt_width(STRETCH);
    localparam int REQ_W   = $bits(sm_req_t);

    sm_req_t raw, syn;
    logic    arm_pend, frc_edge;
    logic    unused_inputs;

    // only crate 0 owns the request lines; others are spare
    assign raw.arm  = arm_req_i[0];
    assign raw.frc  = force_req_i[0];
    assign raw.acc  = trig_accept_i;
    assign raw.per  = trig_period_i;
    assign raw.stat = trig_qual_i[STAT_BIT];
    assign unused_inputs = ^{arm_req_i, force_req_i, trig_qual_i};

    sm_sync #(.W(REQ_W), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (syn)
    );

    sm_save_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_i      (syn),
        .save_o     (save_o),
        .arm_pend_o (arm_pend),
        .frc_edge_o (frc_edge)
    );

    sm_stretch #(.LEN(STRETCH), .W(CNT_W)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .trig_i (save_o),
        .led_o  (save_led_o)
    );

    assign arm_led_o   = syn.arm;
    assign force_led_o = syn.frc;
endmodule

// File: rtl/save_mon_chk.sv
module save_mon_chk (
    input logic clk,
    input logic rst,
    input logic save_o,
    input logic save_led_o,
    input logic force_led_o,
    input logic arm_pend,
    input logic frc_edge
);
    AST_FORCE_SAVE: assert property (@(posedge clk) disable iff (rst)
        $rose(force_led_o) |=> save_o); // R2
    AST_FORCE_HELD: assert property (@(posedge clk) disable iff (rst)
        (force_led_o && $past(force_led_o) && !arm_pend) |=> !save_o); // R2
    AST_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!arm_pend && !frc_edge) |=> !save_o); // R5
    AST_LED_ON: assert property (@(posedge clk) disable iff (rst)
        save_o |=> save_led_o); // R6
    AST_LED_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(save_led_o) |-> !$past(save_o)); // R6
endmodule

bind save_mon_gen save_mon_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .save_o      (save_o),
    .save_led_o  (save_led_o),
    .force_led_o (force_led_o),
    .arm_pend    (arm_pend),
    .frc_edge    (frc_edge)
);

// File: tb/save_mon_gen_tb.sv
`timescale 1ns/1ps
module save_mon_gen_tb;
    localparam int CLK_HZ = 20_000;
    localparam int MS     = 1;
    localparam int LEN    = 20;
    localparam int NC     = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] arm_req = '0, force_req = '0;
    logic          acc = 1'b0, per = 1'b0;
    logic [7:0]    qual = '0;
    logic          save_o, save_led_o, arm_led_o, force_led_o;

    int n_chk = 0, n_fail = 0, save_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    save_mon_gen #(.CLK_HZ(CLK_HZ), .STRETCH_MS(MS), .N_CRATES(NC)) u_dut (
        .clk(clk), .rst(rst), .arm_req_i(arm_req), .force_req_i(force_req),
        .trig_accept_i(acc), .trig_period_i(per), .trig_qual_i(qual),
        .save_o(save_o), .save_led_o(save_led_o),
        .arm_led_o(arm_led_o), .force_led_o(force_led_o)
    );

    always @(negedge clk) if (save_o) save_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fire_accept(input logic p, input logic [7:0] q);
        acc = 1'b1; per = p; qual = q;
        step(1);
        acc = 1'b0; per = 1'b0; qual = '0;
    endtask

    task automatic arm_once();
        arm_req[0] = 1'b1; step(4);
        arm_req[0] = 1'b0; step(2);
    endtask

    task automatic t_reset();
        step(1);
        chk("R9 save_o in reset", save_o, 0);
        chk("R9 save_led_o in reset", save_led_o, 0);
        chk("R9 arm_led_o in reset", arm_led_o, 0);
        chk("R9 force_led_o in reset", force_led_o, 0);
        rst = 1'b0;
        step(3);
    endtask

    task automatic t_arm_accept();
        int base;
        base = save_cnt;
        arm_req[0] = 1'b1;
        step(1); chk("R7 arm_led after 1", arm_led_o, 0);
        step(1); chk("R7 arm_led after 2", arm_led_o, 1);
        step(2); arm_req[0] = 1'b0; step(2);
        fire_accept(1'b1, 8'h80);
        step(1); chk("R1 save before due", save_o, 0);
        step(1); chk("R1 save due", save_o, 1);
        step(1); chk("R1 save one cycle", save_o, 0);
        step(25);
        chk("R1 single pulse", save_cnt - base, 1);
        fire_accept(1'b1, 8'h80);
        step(25);
        chk("R4 arm cleared after save", save_cnt - base, 1);
    endtask

    task automatic t_no_arm();
        int base;
        base = save_cnt;
        fire_accept(1'b1, 8'hFF);
        step(25);
        chk("R5 no save without arm", save_cnt - base, 0);
    endtask

    task automatic t_qual();
        int base;
        base = save_cnt;
        arm_once();
        fire_accept(1'b1, 8'h7F); step(4);
        fire_accept(1'b0, 8'h80); step(4);
        chk("R3 unqualified accepts ignored", save_cnt - base, 0);
        fire_accept(1'b1, 8'h80);
        step(2); chk("R3 arm survived, save due", save_o, 1);
        step(25);
        chk("R3 one save", save_cnt - base, 1);
    endtask

    task automatic t_force();
        int base;
        base = save_cnt;
        force_req[0] = 1'b1;
        step(2); chk("R7 force_led", force_led_o, 1);
        step(1); chk("R2 force save due", save_o, 1);
        step(1); chk("R2 force save one cycle", save_o, 0);
        step(10);
        force_req[0] = 1'b0;
        step(25);
        chk("R2 held force gives one save", save_cnt - base, 1);
    endtask

    task automatic t_led();
        force_req[0] = 1'b1; step(1); force_req[0] = 1'b0;        // A+1
        step(2); chk("R6 led off with save", save_led_o, 0);       // A+3
        step(1); chk("R6 led on after save", save_led_o, 1);       // A+4
        step(6);                                                    // A+10
        force_req[0] = 1'b1; step(1); force_req[0] = 1'b0;        // A+11
        step(13); chk("R6 retrigger extends", save_led_o, 1);      // A+24
        step(9);  chk("R6 last lit cycle", save_led_o, 1);         // A+33
        step(1);  chk("R6 led off after stretch", save_led_o, 0);  // A+34
        step(5);
    endtask

    task automatic t_spare();
        int base;
        base = save_cnt;
        arm_req = 4'b1110; force_req = 4'b1110;
        step(4);
        chk("R8 spare arm hidden", arm_led_o, 0);
        chk("R8 spare force hidden", force_led_o, 0);
        fire_accept(1'b1, 8'h80);
        arm_req = '0; force_req = '0;
        step(25);
        chk("R8 spare requests no save", save_cnt - base, 0);
    endtask

    initial begin
        t_reset();
        t_arm_accept();
        t_no_arm();
        t_qual();
        t_force();
        t_led();
        t_spare();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule